// File: doc/BRIEF.md
# Ordered Store Queue with Read-Triggered Drain

This block sits between one core and a packet network. It keeps that core's memory traffic in total store order. Writes from the core are held in a small queue and produce no network traffic while the queue has room. A read is compared against every held write. If no held write has the read's address, the read goes out at once. If one or more held writes match, the queue first sends its oldest entries, up to and including the youngest match. Only then is the read sent. The block never returns data from the queue to the core.

Flush and atomic requests empty the whole queue before they complete. An atomic request then sends its own packet. Stores always leave the queue oldest first, one packet per cycle. Both the request side and the network side use valid/ready handshakes. A side that raises valid must hold valid and its payload steady until ready is seen high at a clock edge. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and a packet leaves on an edge where `pkt_valid` and `pkt_ready` are both high. While the network holds `pkt_ready` low, the block keeps the same packet on the port. While a request has to wait behind a drain, the block holds `req_ready` low.

Top module: `store_order_queue`

## Requirements
- R1: A write request (`req_op`=0) that arrives while the queue holds fewer than DEPTH entries is accepted in that same cycle and sends no packet.
- R2: A write request that arrives while the queue is full is not accepted. The oldest entry is sent first as a store packet (`pkt_kind`=0, with the stored address and data). The write is accepted in the cycle after that packet leaves.
- R3: A read request (`req_op`=1) whose address matches no held entry sends a load packet (`pkt_kind`=1, the read address, data zero). The request is accepted in the same cycle that the load packet leaves.
- R4: A read whose address matches one or more held entries first sends every entry from the oldest up to and including the youngest match as store packets. The load packet is sent after them.
- R5: Stores leave oldest first. Entries left behind after a partial drain keep their relative order.
- R6: A flush request (`req_op`=2) drains every held entry as store packets. It is then accepted without sending any packet of its own.
- R7: An atomic request (`req_op`=3) drains every held entry. It then sends an atomic packet (`pkt_kind`=2, the request address and data) and is accepted in the same cycle that packet leaves.
- R8: At most one packet leaves per cycle. While `pkt_valid` is high and `pkt_ready` is low, the packet fields stay unchanged in the next cycle.
- R9: After reset the queue is empty and `pkt_valid` and `req_ready` are low. With no request valid, no packet is sent, whatever the queue holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 write, 1 read, 2 flush, 3 atomic |
| req_addr | input | AW | Request address |
| req_data | input | DW | Write or atomic data |
| pkt_valid | output | 1 | Packet offered to the network |
| pkt_ready | input | 1 | Network takes the packet |
| pkt_kind | output | 2 | 0 store, 1 load, 2 atomic |
| pkt_addr | output | AW | Packet address |
| pkt_data | output | DW | Packet data (zero for loads) |

## Verification
A wrong head pointer or a slot left marked valid would show up at the packet port. The next drain would send a store packet with the wrong address or data, or in the wrong order. The same fault would also show as a missing or extra store before a read or atomic, within the drain that follows. A broken address comparison would show on the first read that reuses a held address: the load would leave before its stores, or stores would leave before a read that misses. A bad full or empty decision would show on the next write to a full queue, or on the next flush: a store would be overwritten and never sent, or a request would stall forever.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_READ   = 2'd1,
    OP_FLUSH  = 2'd2,
    OP_ATOMIC = 2'd3
  } sb_op_e;

  typedef enum logic [1:0] {
    PK_STORE  = 2'd0,
    PK_LOAD   = 2'd1,
    PK_ATOMIC = 2'd2,
    PK_RSVD   = 2'd3
  } sb_kind_e;
endpackage

// File: rtl/sbuf_slots.sv
// Circular storage of held writes with per-slot valid bits.
module sbuf_slots #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [AW-1:0]              push_addr,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [AW-1:0]              head_addr,
  output logic [DW-1:0]              head_data,
  output logic [DEPTH-1:0]           slot_valid,
  output logic [DEPTH-1:0][AW-1:0]   slot_addr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] head_q, tail_q;
  logic [DEPTH-1:0][DW-1:0] slot_data;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      tail_q     <= '0;
      slot_valid <= '0;
    end else begin
      if (push) begin
        tail_q             <= advance(tail_q);
        slot_valid[tail_q] <= 1'b1;
      end
      if (pop) begin
        head_q             <= advance(head_q);
        slot_valid[head_q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail_q] <= push_addr;
      slot_data[tail_q] <= push_data;
    end
  end

  assign head_addr = slot_addr[head_q];
  assign head_data = slot_data[head_q];
endmodule

// File: rtl/sbuf_match.sv
// Compares a read address against every valid held slot.
module sbuf_match #(
  parameter int DEPTH = 4,
  parameter int AW    = 16
) (
  input  logic [DEPTH-1:0]         slot_valid,
  input  logic [DEPTH-1:0][AW-1:0] slot_addr,
  input  logic [AW-1:0]            probe_addr,
  output logic                     hit
);
  logic [DEPTH-1:0] eq;
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = slot_valid[i] && (slot_addr[i] == probe_addr);
  end
  assign hit = |eq;
endmodule

// File: rtl/store_order_queue.sv
module store_order_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          pkt_valid,
  input  logic          pkt_ready,
  output logic [1:0]    pkt_kind,
  output logic [AW-1:0] pkt_addr,
  output logic [DW-1:0] pkt_data
);
  import sbuf_pkg::*;

  logic                     push, pop, drain, hit, full, empty;
  logic [AW-1:0]            head_addr;
  logic [DW-1:0]            head_data;
  logic [DEPTH-1:0]         slot_valid;
  logic [DEPTH-1:0][AW-1:0] slot_addr;
  sb_op_e                   op;
  sb_kind_e                 kind;

  sbuf_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) slots_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(req_addr),
    .push_data(req_data), .pop(pop), .head_addr(head_addr),
    .head_data(head_data), .slot_valid(slot_valid), .slot_addr(slot_addr)
  );

  sbuf_match #(.DEPTH(DEPTH), .AW(AW)) match_i (
    .slot_valid(slot_valid), .slot_addr(slot_addr),
    .probe_addr(req_addr), .hit(hit)
  );

  assign op    = sb_op_e'(req_op);
  assign full  = &slot_valid;
  assign empty = ~|slot_valid;

  // A matching read keeps draining the head until no match is left,
  // which stops exactly after the youngest matching entry.
  always_comb begin
    req_ready = 1'b0;
    pkt_valid = 1'b0;
    kind      = PK_STORE;
    pkt_addr  = head_addr;
    pkt_data  = head_data;
    drain     = 1'b0;
    push      = 1'b0;
    if (req_valid) begin
      case (op)
        OP_WRITE: begin
          if (!full) begin
            req_ready = 1'b1;
            push      = 1'b1;
          end else begin
            drain = 1'b1;
          end
        end
        OP_READ: begin
          if (hit) begin
            drain = 1'b1;
          end else begin
            pkt_valid = 1'b1;
            kind      = PK_LOAD;
            pkt_addr  = req_addr;
            pkt_data  = '0;
            req_ready = pkt_ready;
          end
        end
        OP_FLUSH: begin
          if (!empty) drain = 1'b1;
          else        req_ready = 1'b1;
        end
        default: begin
          if (!empty) begin
            drain = 1'b1;
          end else begin
            pkt_valid = 1'b1;
            kind      = PK_ATOMIC;
            pkt_addr  = req_addr;
            pkt_data  = req_data;
            req_ready = pkt_ready;
          end
        end
      endcase
    end
    if (drain) pkt_valid = 1'b1;
  end

  assign pop      = drain && pkt_ready;
  assign pkt_kind = kind;
endmodule

// File: rtl/store_order_queue_chk.sv
module store_order_queue_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_data,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [1:0]    pkt_kind,
  input logic [AW-1:0] pkt_addr,
  input logic [DW-1:0] pkt_data
);
  localparam int CW = $clog2(DEPTH + 1) + 1;
  logic [CW-1:0] occ;
  logic wr_take, st_out;

  assign wr_take = req_valid && req_ready && (req_op == 2'd0);
  assign st_out  = pkt_valid && pkt_ready && (pkt_kind == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ + CW'(wr_take) - CW'(st_out);
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (occ < CW'(DEPTH)));
  // R2
  full_drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && occ == CW'(DEPTH)) |-> (!req_ready && pkt_valid && pkt_kind == 2'd0));
  // R3
  load_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'd1) |-> (req_valid && req_op == 2'd1 && pkt_addr == req_addr));
  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd2) |-> (occ == '0));
  // R7
  atomic_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_kind == 2'd2) |-> (occ == '0));
  // R8
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_kind) && $stable(pkt_addr) && $stable(pkt_data)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !pkt_valid);
endmodule

bind store_order_queue store_order_queue_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (.*);

// File: tb/store_order_queue_tb.sv
module store_order_queue_tb_top;
  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          pkt_valid;
  logic          pkt_ready = 1'b0;
  logic [1:0]    pkt_kind;
  logic [AW-1:0] pkt_addr;
  logic [DW-1:0] pkt_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference queue of held writes
  logic [AW-1:0] m_addr[$];
  logic [DW-1:0] m_data[$];
  // expected packets for the current request
  logic [1:0]    e_kind[$];
  logic [AW-1:0] e_addr[$];
  logic [DW-1:0] e_data[$];

  store_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  function automatic void expect_store_front();
    e_kind.push_back(2'd0);
    e_addr.push_back(m_addr[0]);
    e_data.push_back(m_data[0]);
    void'(m_addr.pop_front());
    void'(m_data.pop_front());
  endfunction

  // expected packets per R1..R7
  function automatic void model(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int j;
    case (op)
      2'd0: begin // R1, R2
        if (m_addr.size() == DEPTH) expect_store_front();
        m_addr.push_back(a); m_data.push_back(d);
      end
      2'd1: begin // R3, R4
        j = -1;
        foreach (m_addr[i]) if (m_addr[i] == a) j = i;
        for (int k = 0; k <= j; k++) expect_store_front();
        e_kind.push_back(2'd1); e_addr.push_back(a); e_data.push_back('0);
      end
      2'd2: while (m_addr.size() > 0) expect_store_front(); // R6
      default: begin // R7
        while (m_addr.size() > 0) expect_store_front();
        e_kind.push_back(2'd2); e_addr.push_back(a); e_data.push_back(d);
      end
    endcase
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input int rdy_pct);
    string tag;
    bit done = 0;
    model(op, a, d);
    tag = (op == 2'd0) ? "R1/R2/R5" : (op == 2'd1) ? "R3/R4/R5" : (op == 2'd2) ? "R6/R5" : "R7/R5";
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    while (!done) begin
      pkt_ready = ($urandom_range(99) < rdy_pct);
      #1;
      if (pkt_valid && pkt_ready) begin
        if (e_kind.size() == 0) begin
          chk(0, {tag, " extra packet"}, {pkt_kind, pkt_addr}, 0);
        end else begin
          chk(pkt_kind == e_kind[0] && pkt_addr == e_addr[0] && pkt_data == e_data[0],
              {tag, " packet"}, {14'd0, pkt_kind, pkt_addr, pkt_data},
              {14'd0, e_kind[0], e_addr[0], e_data[0]});
          void'(e_kind.pop_front()); void'(e_addr.pop_front()); void'(e_data.pop_front());
        end
      end
      if (req_ready) done = 1;
      else @(negedge clk);
    end
    @(posedge clk);
    chk(e_kind.size() == 0, {tag, " missing packets"}, e_kind.size(), 0);
    e_kind.delete(); e_addr.delete(); e_data.delete();
  endtask

  // R9: idle cycle, nothing may leave whatever is held
  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0; pkt_ready = 1'b1;
    #1;
    chk(!pkt_valid, "R9 idle", pkt_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd2417));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!pkt_valid && !req_ready, "R9 reset", {pkt_valid, req_ready}, 0);

    // directed: fill with duplicates, read hits youngest match (R4, R5)
    do_op(2'd0, 16'h10, 32'hA0, 100);
    do_op(2'd0, 16'h20, 32'hA1, 100);
    do_op(2'd0, 16'h10, 32'hA2, 100);
    do_op(2'd0, 16'h30, 32'hA3, 100);
    idle_check();
    do_op(2'd0, 16'h40, 32'hA4, 50);   // R2 full write
    do_op(2'd1, 16'h10, 32'h0, 60);    // R4 drains to youngest 0x10
    do_op(2'd1, 16'h99, 32'h0, 100);   // R3 miss
    do_op(2'd2, 16'h0, 32'h0, 40);     // R6 flush
    do_op(2'd2, 16'h0, 32'h0, 100);    // R6 flush on empty
    do_op(2'd3, 16'h55, 32'hBEEF, 100); // R7 atomic on empty
    do_op(2'd0, 16'h5, 32'hC0, 100);
    do_op(2'd3, 16'h56, 32'hCAFE, 30); // R7 atomic after drain, R8 stalls

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(99);
      logic [1:0] op = (r < 50) ? 2'd0 : (r < 80) ? 2'd1 : (r < 90) ? 2'd2 : 2'd3;
      if ($urandom_range(9) == 0) idle_check();
      do_op(op, AW'($urandom_range(7)), $urandom, 20 + $urandom_range(80));
    end

    @(negedge clk);
    req_valid = 1'b0;
    finish_run();
  end
endmodule